// File: doc/BRIEF.md
# Panel Supply Rail Sequencer

This block brings up the supplies and drive signals of a flat display panel in a fixed order and takes them down again in the opposite order. While the power request input is high it switches on six stages one after another. The stages are the logic supply, the gate-low supply, the combined analog, gamma and gate-high supplies, the gate-in-panel supply lines, the gate start pulse and gate clocks, and last the backlight. Each step waits for a minimum gap before the next one. The first three stages also wait for their power-good input. When the request drops, the enabled stages are switched off from the top down, with the same gaps.

All timing is counted in ticks. One tick is `TICK_CLKS` clock cycles, so with a 100 MHz clock and the default of 50 000 cycles a tick lasts 0.5 ms. Every delay restarts its own tick count when it is loaded, so each gap is a whole number of ticks and never shorter. After the last stage goes off, the block enforces a re-power lockout of `LOCKOUT_TICKS`, which is 2 s by default. A supply that never reports good ends the power-up with a fault. The block has no data stream. All of its pins are plain control and status levels with no handshake and no back-pressure.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, all six enables, `ready`, `busy` and `fault` are low.
- R2: Stages switch on in this order: logic, gate-low, analog, gate supply, gate drive, backlight. Stages switch off in the exact reverse order. At any time the enabled set is a prefix of that order, and it changes by at most one stage per clock.
- R3: With the block idle, not faulted and past any lockout, the logic enable rises on the first clock edge that samples `pwr_req` high.
- R4: For stages 1 to 3 (logic, gate-low, analog), the gap before the next stage starts counting on the edge after the matching power-good is sampled high. If that power-good is first seen P cycles after the enable, the next enable follows P + gap×`TICK_CLKS` + 1 cycles after this one.
- R5: For stages 4 and 5, the next enable follows exactly gap×`TICK_CLKS` + 1 cycles after this one. The gaps that follow stages 1 to 5 are `GAP_LOGIC`, `GAP_VGL`, `GAP_RAIL`, `GAP_GATE` and `GAP_START`.
- R6: At power-off, the enable of stage s (s = 1..5) falls gap(s)×`TICK_CLKS` + 1 cycles after the enable of stage s+1.
- R7: `busy` stays high through the lockout and falls `LOCKOUT_TICKS`×`TICK_CLKS` + 1 cycles after the logic enable falls. If `pwr_req` is held high through the lockout, the logic enable rises again exactly `LOCKOUT_TICKS`×`TICK_CLKS` + 2 cycles after it fell.
- R8: If `pwr_req` is sampled low during power-up, the highest enabled stage falls on that same edge and no further stage is switched on.
- R9: If a sensed stage's power-good is still low `PG_TIMEOUT_TICKS`×`TICK_CLKS` cycles after its enable, that enable falls one cycle later and `fault` rises. The rest then powers down in reverse order.
- R10: While `fault` is high, no stage switches on, even with `pwr_req` high. `fault` clears on the first edge in the idle state that samples `pwr_req` low.
- R11: `ready` is high exactly while all six stages are on and the sequence has completed. It drops on the edge that removes the backlight. `busy` is high in every sequencing or lockout state and low when idle or ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req | input | 1 | Level request: high to power the panel |
| pg_logic | input | 1 | Logic supply good |
| pg_gate_low | input | 1 | Gate-low supply good |
| pg_analog | input | 1 | Analog/gamma/gate-high supplies good |
| en_logic | output | 1 | Stage 1 enable: logic supply |
| en_gate_low | output | 1 | Stage 2 enable: gate-low supply |
| en_analog | output | 1 | Stage 3 enable: analog, gamma, gate-high supplies |
| en_gate_supply | output | 1 | Stage 4 enable: odd/even gate-in-panel supply lines |
| en_gate_drive | output | 1 | Stage 5 enable: gate start pulse and gate clocks |
| en_backlight | output | 1 | Stage 6 enable: LED backlight |
| ready | output | 1 | Sequence complete, panel fully on |
| busy | output | 1 | Sequencing up or down, or in lockout |
| fault | output | 1 | A power-good timed out; sticky until the request is withdrawn |

## Verification
The bench builds the block with a two-cycle tick and gaps of 1, 2, 0, 3 and 2 ticks. It also uses a five-tick lockout and a four-tick power-good timeout. With these values a whole power-up, power-down and lockout takes a few dozen cycles, so every interval can be checked to the exact cycle. The zero rail gap exercises the path where a delay expires at once. A bench model answers each power-good after a chosen latency, which the bench sweeps over several values. The bench also aborts at every stage and forces a timeout on each of the three sensed supplies.

// File: rtl/panel_pwr_pkg.sv
package panel_pwr_pkg;

  localparam int NUM_STAGES = 6;  // logic, gate-low, analog, gate supply, gate drive, backlight
  localparam int NUM_SENSED = 3;  // stages 1..3 report power-good
  localparam int LW         = $clog2(NUM_STAGES + 1);

  typedef enum logic [2:0] {
    PS_OFF,     // idle, nothing enabled
    PS_PGWAIT,  // top stage enabled, waiting for its power-good
    PS_HOLD,    // waiting out the gap before the next stage
    PS_ON,      // all stages on
    PS_FALL,    // waiting out the gap before the next stage goes off
    PS_LOCK     // re-power lockout
  } pseq_state_e;

endpackage

// File: rtl/panel_pwr_timer.sv
module panel_pwr_timer #(
  parameter int TICK_CLKS = 50000,
  parameter int CW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_ticks,
  output logic          expired
);

  localparam int SW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(TICK_CLKS - 1);

  logic [SW-1:0] sub_q;
  logic [CW-1:0] rem_q;

  // The tick prescaler restarts with every load, so a delay of N ticks
  // lasts exactly N*TICK_CLKS cycles from the loading edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      sub_q <= '0;
      rem_q <= load_ticks;
    end else if (rem_q != '0) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        rem_q <= rem_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign expired = (rem_q == '0);

endmodule

// File: rtl/panel_pwr_fsm.sv
module panel_pwr_fsm
  import panel_pwr_pkg::*;
#(
  parameter int CW               = 12,
  parameter int GAP_LOGIC        = 1,
  parameter int GAP_VGL          = 1,
  parameter int GAP_RAIL         = 0,
  parameter int GAP_GATE         = 20,
  parameter int GAP_START        = 40,
  parameter int LOCKOUT_TICKS    = 4000,
  parameter int PG_TIMEOUT_TICKS = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [NUM_SENSED-1:0] pg,
  input  logic                  tmr_done,
  output logic                  tmr_load,
  output logic [CW-1:0]         tmr_ticks,
  output logic [LW-1:0]         nxt_level,
  output logic                  ready,
  output logic                  busy,
  output logic                  fault
);

  localparam logic [LW-1:0] TOP_LVL = LW'(NUM_STAGES);
  localparam logic [LW-1:0] SENSED  = LW'(NUM_SENSED);

  pseq_state_e   st_q, st_d;
  logic [LW-1:0] lvl_q;
  logic          flt_d;

  logic [LW-1:0] up_lvl, dn_lvl;
  pseq_state_e   up_st, dn_st;
  logic [CW-1:0] up_ticks, dn_ticks;
  logic          do_up, do_dn, pg_cur;

  // Gap that follows stage s on the way up, and precedes its removal on the way down.
  function automatic logic [CW-1:0] gap_of(input logic [LW-1:0] s);
    case (s)
      LW'(1):  gap_of = CW'(GAP_LOGIC);
      LW'(2):  gap_of = CW'(GAP_VGL);
      LW'(3):  gap_of = CW'(GAP_RAIL);
      LW'(4):  gap_of = CW'(GAP_GATE);
      LW'(5):  gap_of = CW'(GAP_START);
      default: gap_of = '0;
    endcase
  endfunction

  always_comb begin
    pg_cur = 1'b0;
    for (int i = 0; i < NUM_SENSED; i++) begin
      if (lvl_q == LW'(i + 1)) pg_cur = pg[i];
    end
  end

  // Prepared step up and step down, picked by the state logic below.
  always_comb begin
    up_lvl = lvl_q + 1'b1;
    if (up_lvl == TOP_LVL) begin
      up_st    = PS_ON;
      up_ticks = '0;
    end else if (up_lvl <= SENSED) begin
      up_st    = PS_PGWAIT;
      up_ticks = CW'(PG_TIMEOUT_TICKS);
    end else begin
      up_st    = PS_HOLD;
      up_ticks = gap_of(up_lvl);
    end

    dn_lvl = lvl_q - 1'b1;
    if (dn_lvl == '0) begin
      dn_st    = PS_LOCK;
      dn_ticks = CW'(LOCKOUT_TICKS);
    end else begin
      dn_st    = PS_FALL;
      dn_ticks = gap_of(dn_lvl);
    end
  end

  always_comb begin
    st_d      = st_q;
    nxt_level = lvl_q;
    flt_d     = fault;
    tmr_load  = 1'b0;
    tmr_ticks = '0;
    do_up     = 1'b0;
    do_dn     = 1'b0;

    case (st_q)
      PS_OFF: begin
        if (!req)        flt_d = 1'b0;
        else if (!fault) do_up = 1'b1;
      end
      PS_PGWAIT: begin
        if (!req) begin
          do_dn = 1'b1;
        end else if (pg_cur) begin
          st_d      = PS_HOLD;
          tmr_load  = 1'b1;
          tmr_ticks = gap_of(lvl_q);
        end else if (tmr_done) begin
          do_dn = 1'b1;
          flt_d = 1'b1;
        end
      end
      PS_HOLD: begin
        if (!req)          do_dn = 1'b1;
        else if (tmr_done) do_up = 1'b1;
      end
      PS_ON: begin
        if (!req) do_dn = 1'b1;
      end
      PS_FALL: begin
        if (tmr_done) do_dn = 1'b1;
      end
      PS_LOCK: begin
        if (tmr_done) st_d = PS_OFF;
      end
      default: st_d = PS_OFF;
    endcase

    if (do_up) begin
      st_d      = up_st;
      nxt_level = up_lvl;
      tmr_load  = (up_st != PS_ON);
      tmr_ticks = up_ticks;
    end else if (do_dn) begin
      st_d      = dn_st;
      nxt_level = dn_lvl;
      tmr_load  = 1'b1;
      tmr_ticks = dn_ticks;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_OFF;
      lvl_q <= '0;
      fault <= 1'b0;
    end else begin
      st_q  <= st_d;
      lvl_q <= nxt_level;
      fault <= flt_d;
    end
  end

  assign ready = (st_q == PS_ON);
  assign busy  = (st_q != PS_ON) && (st_q != PS_OFF);

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import panel_pwr_pkg::*;
#(
  parameter int TICK_CLKS        = 50000,
  parameter int GAP_LOGIC        = 1,
  parameter int GAP_VGL          = 1,
  parameter int GAP_RAIL         = 0,
  parameter int GAP_GATE         = 20,
  parameter int GAP_START        = 40,
  parameter int LOCKOUT_TICKS    = 4000,
  parameter int PG_TIMEOUT_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic pg_logic,
  input  logic pg_gate_low,
  input  logic pg_analog,
  output logic en_logic,
  output logic en_gate_low,
  output logic en_analog,
  output logic en_gate_supply,
  output logic en_gate_drive,
  output logic en_backlight,
  output logic ready,
  output logic busy,
  output logic fault
);

  localparam int CW = $clog2(LOCKOUT_TICKS + PG_TIMEOUT_TICKS + GAP_LOGIC + GAP_VGL +
                             GAP_RAIL + GAP_GATE + GAP_START + 2);

  logic                  tmr_load, tmr_done;
  logic [CW-1:0]         tmr_ticks;
  logic [LW-1:0]         nxt_level;
  logic [NUM_SENSED-1:0] pg_vec;
  logic [NUM_STAGES-1:0] stage_en;

  assign pg_vec = {pg_analog, pg_gate_low, pg_logic};

  panel_pwr_timer #(
    .TICK_CLKS (TICK_CLKS),
    .CW        (CW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (tmr_load),
    .load_ticks (tmr_ticks),
    .expired    (tmr_done)
  );

  panel_pwr_fsm #(
    .CW               (CW),
    .GAP_LOGIC        (GAP_LOGIC),
    .GAP_VGL          (GAP_VGL),
    .GAP_RAIL         (GAP_RAIL),
    .GAP_GATE         (GAP_GATE),
    .GAP_START        (GAP_START),
    .LOCKOUT_TICKS    (LOCKOUT_TICKS),
    .PG_TIMEOUT_TICKS (PG_TIMEOUT_TICKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (pwr_req),
    .pg        (pg_vec),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_ticks (tmr_ticks),
    .nxt_level (nxt_level),
    .ready     (ready),
    .busy      (busy),
    .fault     (fault)
  );

  // One flop per stage, decoded from the next level, so the enables never glitch.
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_en[g] <= 1'b0;
      else        stage_en[g] <= (nxt_level > LW'(g));
    end
  end

  assign en_logic       = stage_en[0];
  assign en_gate_low    = stage_en[1];
  assign en_analog      = stage_en[2];
  assign en_gate_supply = stage_en[3];
  assign en_gate_drive  = stage_en[4];
  assign en_backlight   = stage_en[5];

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk #(
  parameter int NST      = 6,
  parameter int LOCK_CYC = 200000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req,
  input logic [NST-1:0] stage_en,
  input logic           ready,
  input logic           busy,
  input logic           fault
);

  logic        past_ok;
  int unsigned off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      off_cnt <= LOCK_CYC;
    end else begin
      past_ok <= 1'b1;
      if (stage_en[0])              off_cnt <= 0;
      else if (off_cnt < LOCK_CYC)  off_cnt <= off_cnt + 1;
    end
  end

  // R2: the enabled set is always a prefix of the power-on order
  a_r2_prefix_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_en & (stage_en + 1'b1)) == '0));

  // R2: at most one stage changes per clock
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ($countones(stage_en ^ $past(stage_en)) <= 1));

  // R11: ready only with every stage on and not busy
  a_r11_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((&stage_en) && !busy));

  // R8: no stage is added on an edge that sampled the request low
  a_r8_no_rise_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(req)) |-> ($countones(stage_en) <= $countones($past(stage_en))));

  // R10: while faulted no stage is added
  a_r10_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(fault) && fault) |-> ($countones(stage_en) <= $countones($past(stage_en))));

  // R7: logic supply returns only after the full lockout
  a_r7_lockout_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_en[0]) |-> (off_cnt >= LOCK_CYC));

endmodule

bind panel_pwr_seq panel_pwr_seq_chk #(
  .NST      (6),
  .LOCK_CYC (TICK_CLKS * LOCKOUT_TICKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (pwr_req),
  .stage_en (stage_en),
  .ready    (ready),
  .busy     (busy),
  .fault    (fault)
);

// File: tb/panel_pwr_seq_bench.sv
`timescale 1ns/1ps
module panel_pwr_seq_bench;

  localparam int T   = 2;
  localparam int GL  = 1, GV = 2, GR = 0, GG = 3, GS = 2;
  localparam int LK  = 5;
  localparam int PTO = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic pg_l, pg_g, pg_a;
  logic en_l, en_g, en_a, en_gs, en_gd, en_bl, ready, busy, fault;
  logic [5:0] env;

  always #2.5 clk = ~clk;

  panel_pwr_seq #(
    .TICK_CLKS (T), .GAP_LOGIC (GL), .GAP_VGL (GV), .GAP_RAIL (GR),
    .GAP_GATE (GG), .GAP_START (GS), .LOCKOUT_TICKS (LK), .PG_TIMEOUT_TICKS (PTO)
  ) u_panel_pwr_seq (
    .clk (clk), .rst_n (rst_n), .pwr_req (req),
    .pg_logic (pg_l), .pg_gate_low (pg_g), .pg_analog (pg_a),
    .en_logic (en_l), .en_gate_low (en_g), .en_analog (en_a),
    .en_gate_supply (en_gs), .en_gate_drive (en_gd), .en_backlight (en_bl),
    .ready (ready), .busy (busy), .fault (fault)
  );

  assign env = {en_bl, en_gd, en_gs, en_a, en_g, en_l};

  // Power-good model: each sensed supply reports good pg_lat cycles after its enable.
  int pg_lat = 0;
  logic [2:0] kill = 3'b000;
  int pgcnt [3];
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!env[i]) pgcnt[i] <= 0;
      else if (pgcnt[i] < 1000) pgcnt[i] <= pgcnt[i] + 1;
    end
  end
  assign pg_l = env[0] && !kill[0] && (pgcnt[0] >= pg_lat);
  assign pg_g = env[1] && !kill[1] && (pgcnt[1] >= pg_lat);
  assign pg_a = env[2] && !kill[2] && (pgcnt[2] >= pg_lat);

  int n_cmp = 0, n_bad = 0, cyc = 0, maxlvl = 0, bt = 0;
  int rt [6];
  int ft [6];
  logic [5:0] prev = '0;
  logic prev_busy = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < 6; i++) begin
      if (env[i] && !prev[i]) rt[i] = cyc;
      if (!env[i] && prev[i]) ft[i] = cyc;
    end
    if (prev_busy && !busy) bt = cyc;
    if ($countones(env) > maxlvl) maxlvl = $countones(env);
    prev = env;
    prev_busy = busy;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic int gap(input int s);
    case (s)
      1: return GL;
      2: return GV;
      3: return GR;
      4: return GG;
      5: return GS;
      default: return 0;
    endcase
  endfunction

  task automatic wait_idle();
    while (busy || env != 0) step();
  endtask

  task automatic full_cycle(input int lat);
    int c0;
    pg_lat = lat;
    wait_idle();
    req = 1'b1;
    c0 = cyc;
    while (!ready) step();
    chk("R3 request to logic enable", rt[0] - c0, 1);
    for (int s = 1; s <= 5; s++) begin
      if (s <= 3) chk($sformatf("R4 up gap after stage %0d lat %0d", s, lat), rt[s] - rt[s-1], lat + gap(s) * T + 2);
      else        chk($sformatf("R5 up gap after stage %0d", s), rt[s] - rt[s-1], gap(s) * T + 1);
    end
    chk("R11 ready with all on", int'(env), 63);
    chk("R11 not busy when ready", int'(busy), 0);
    req = 1'b0;
    c0 = cyc;
    step();
    chk("R11 ready drops with backlight", int'(ready), 0);
    chk("R8 backlight off on next edge", ft[5] - c0, 1);
    while (env != 0) step();
    for (int s = 1; s <= 5; s++)
      chk($sformatf("R6 down gap stage %0d", s), ft[s-1] - ft[s], gap(s) * T + 1);
    chk("R7 busy in lockout", int'(busy), 1);
    while (busy) step();
    chk("R7 lockout length", bt - ft[0], LK * T + 1);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 enables at reset", int'(env), 0);
    chk("R1 ready at reset", int'(ready), 0);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 fault at reset", int'(fault), 0);
    rst_n = 1'b1;
    step();

    // R2..R7, R11: full cycles over a sweep of power-good latencies
    for (int lat = 0; lat < 4; lat++) full_cycle(lat);

    // R7: request held through the lockout
    pg_lat = 1;
    req = 1'b1;
    while (!ready) step();
    req = 1'b0;
    while (env[0]) step();
    req = 1'b1;
    chk("R7 busy while locked", int'(busy), 1);
    while (!env[0]) step();
    chk("R7 held request re-power time", rt[0] - ft[0], LK * T + 2);
    while (!ready) step();
    chk("R2 all stages back on", int'(env), 63);
    req = 1'b0;
    wait_idle();

    // R8: abort after each stage, for two latencies
    for (int lat = 0; lat < 3; lat += 2) begin
      for (int s = 1; s <= 5; s++) begin
        pg_lat = lat;
        maxlvl = 0;
        req = 1'b1;
        while (!env[s-1]) step();
        req = 1'b0;
        step();
        chk($sformatf("R8 abort stage %0d top falls", s), ft[s-1] - rt[s-1], 1);
        wait_idle();
        chk($sformatf("R8 abort stage %0d highest level", s), maxlvl, s);
        chk($sformatf("R8 abort stage %0d ready never", s), int'(ready), 0);
        for (int k = 1; k < s; k++)
          chk($sformatf("R6 abort stage %0d down gap %0d", s, k), ft[k-1] - ft[k], gap(k) * T + 1);
      end
    end

    // R9, R10: power-good timeout on each sensed supply
    for (int k = 0; k < 3; k++) begin
      pg_lat = 0;
      kill = 3'b001 << k;
      maxlvl = 0;
      req = 1'b1;
      while (!fault) step();
      chk($sformatf("R9 timeout stage %0d", k + 1), ft[k] - rt[k], PTO * T + 1);
      wait_idle();
      chk($sformatf("R9 timeout stage %0d highest", k + 1), maxlvl, k + 1);
      repeat (20) step();
      chk("R10 no re-power while faulted", int'(env), 0);
      chk("R10 fault held", int'(fault), 1);
      req = 1'b0;
      kill = 3'b000;
      step();
      step();
      chk("R10 fault cleared", int'(fault), 0);
    end

    // R10: a normal cycle after the fault works again
    full_cycle(1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule